// File: doc/BRIEF.md
# Indirect Register Access Window

This block is the target side of a small indirect access window on a 32-bit memory-mapped bus. Software uses four word addresses to reach a much larger per-channel internal register space. It first writes a channel number and an internal offset into two window registers. For a write it also loads a 16-bit data value. A write to the control register then launches one internal access. The block carries that access over a simple request/acknowledge port and, for a read, places the returned 16-bit value in the data register.

The internal side can take any number of cycles to respond. While an access is outstanding the block shows a busy flag in the control register. During that time it holds the channel, offset and write data steady and refuses every bus write to the window. A refused write, or a launch that cannot be honoured, sets a sticky error flag, which software clears by writing a 1 to it. Launch strobes are self-clearing, so the control register reads back only the access mode, busy and error.

Top module: `ind_access_port`

## Requirements
- R1: After a synchronous active-low reset, addresses 0x38, 0x3A, 0x3B and 0x3C all read zero and the internal request is low.
- R2: While idle, a write to 0x38 stores the channel (low CHAN_W bits), a write to 0x3B stores the offset (low OFFS_W bits) and a write to 0x3C stores the data (low 16 bits). Each reads back zero-extended, and any unmapped address reads zero.
- R3: Control register 0x3A layout: bits [3:2] are the read/write mode field, bit 8 is the read-only busy flag, bit 9 is the sticky error flag, bit 1 is the read strobe and bit 0 is the write strobe. The strobes always read back as 0, and every other bit reads 0.
- R4: While idle, writing 0x3A with mode 01 and only the read strobe set (value 0x6) launches an internal read. From the next cycle, busy is set, the request is high, the direction output is low, and the stored channel and offset are presented.
- R5: While idle, writing 0x3A with mode 01 and only the write strobe set (value 0x5) launches an internal write. The request is high and the direction output is high, and the data register value is presented as write data.
- R6: Busy and the request stay high until the internal side acknowledges. On the acknowledge edge busy clears. For a read, the data register takes the acknowledged read data on that same edge.
- R7: While busy, bus writes to 0x38, 0x3A, 0x3B and 0x3C are dropped and the error flag is set.
- R8: While idle, a control write that sets a strobe issues no internal access and sets the error flag if the mode field is not 01 or if both strobes are set. The mode field still takes the written value.
- R9: While idle, a control write with bit 9 set clears the error flag. If the same write also raises an error, the error flag stays set.
- R10: Channel, offset and write data presented on the internal port do not change while a request waits for its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (7) | Word address of the bus access |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_wdata | input | BUS_W (32) | Bus write data |
| bus_rdata | output | BUS_W (32) | Read data for the addressed register, combinational |
| int_req | output | 1 | Internal access request, held until acknowledged |
| int_we | output | 1 | Internal access direction, 1 = write |
| int_chan | output | CHAN_W (8) | Logical channel of the internal access |
| int_offs | output | OFFS_W (12) | Internal register offset |
| int_wdata | output | DATA_W (16) | Internal write data |
| int_ack | input | 1 | Internal access complete, one cycle |
| int_rdata | input | DATA_W (16) | Internal read data, valid with int_ack |

## Verification
The bound checker watches, on every clock, the behaviour that can be seen at the ports:
- launch of a read or a write on the exact command values;
- the request held until its acknowledge and dropped right after;
- capture of read data on the acknowledge;
- stable channel, offset and write data while a request waits;
- refusal of launches with a bad mode or both strobes set;
- strobe bits that always read as zero.

Only the bench scenarios can show the remaining behaviour:
- that a write refused while busy really leaves the register untouched;
- that the error flag sets and clears in the right order;
- that data written through the window to a channel and offset comes back on a later read of the same location.

The bench uses a responder whose latency varies and which can hold back its acknowledge on demand.

// File: rtl/iap_pkg.sv
// Package: shared constants and types for the indirect access window.
// Assumes word addressing on the host bus; offsets below are behavioural.
package iap_pkg;
    localparam logic [6:0] ADDR_CHAN = 7'h38;
    localparam logic [6:0] ADDR_CTRL = 7'h3A;
    localparam logic [6:0] ADDR_OFFS = 7'h3B;
    localparam logic [6:0] ADDR_DATA = 7'h3C;

    localparam int BIT_WSTB = 0;   // write strobe, self-clearing
    localparam int BIT_RSTB = 1;   // read strobe, self-clearing
    localparam int BIT_MODE = 2;   // mode field occupies [3:2]
    localparam int BIT_BUSY = 8;   // read-only busy
    localparam int BIT_ERR  = 9;   // sticky error, write 1 to clear

    localparam logic [1:0] MODE_DIRECT = 2'b01;

    // One write-enable per window register
    typedef struct packed {
        logic chan;
        logic ctrl;
        logic offs;
        logic data;
    } win_sel_t;
endpackage

// File: rtl/iap_decode.sv
// Module: iap_decode
// Decodes a bus write into per-register write enables. Enables are only
// raised while idle; a write that hits the window while busy is reported
// as blocked instead. Assumes bus_wr is a single-cycle strobe.
module iap_decode
    import iap_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              busy,
    output win_sel_t          wr_en,
    output logic              blocked
);
    win_sel_t hit;

    // Address match for the four window registers
    always_comb begin
        hit.chan = (addr == ADDR_W'(ADDR_CHAN));
        hit.ctrl = (addr == ADDR_W'(ADDR_CTRL));
        hit.offs = (addr == ADDR_W'(ADDR_OFFS));
        hit.data = (addr == ADDR_W'(ADDR_DATA));
    end

    // Gate enables with idle state; flag writes that arrive while busy
    always_comb begin
        wr_en   = (wr && !busy) ? hit : '0;
        blocked = wr && busy && (|hit);
    end
endmodule

// File: rtl/iap_ctrl.sv
// Module: iap_ctrl
// Launch sequencer: turns an accepted control write into one internal
// access and holds busy until the acknowledge. Assumes ctrl_wr is only
// raised while idle (gated by the decoder).
module iap_ctrl
    import iap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [3:0] cmd,
    input  logic       int_ack,
    output logic       busy,
    output logic       dir_we,
    output logic       launch_err,
    output logic       rd_done
);
    logic mode_ok;
    logic rstb;
    logic wstb;
    logic go;

    // Classify the command: one strobe with mode 01 launches, else error
    always_comb begin
        mode_ok    = (cmd[BIT_MODE+1:BIT_MODE] == MODE_DIRECT);
        rstb       = cmd[BIT_RSTB];
        wstb       = cmd[BIT_WSTB];
        go         = ctrl_wr && (rstb ^ wstb) && mode_ok;
        launch_err = ctrl_wr && (rstb | wstb) && !((rstb ^ wstb) && mode_ok);
        rd_done    = busy && int_ack && !dir_we;
    end

    // Busy/direction state: set on launch, cleared on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            dir_we <= 1'b0;
        end else if (busy && int_ack) begin
            busy   <= 1'b0;
        end else if (go) begin
            busy   <= 1'b1;
            dir_we <= wstb;
        end
    end
endmodule

// File: rtl/iap_regs.sv
// Module: iap_regs
// Window register file: channel, offset, data, mode and sticky error,
// plus the combinational read mux. Assumes write enables are already
// gated by the idle state.
module iap_regs
    import iap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BUS_W  = 32,
    parameter int CHAN_W = 8,
    parameter int OFFS_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_sel_t          wr_en,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              err_set,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic [CHAN_W-1:0] chan_q,
    output logic [OFFS_W-1:0] offs_q,
    output logic [DATA_W-1:0] data_q,
    output logic [BUS_W-1:0]  rdata
);
    logic [1:0] mode_q;
    logic       err_q;
    logic       unused_wdata;

    assign unused_wdata = ^wdata;

    // Channel and offset registers, written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            offs_q <= '0;
        end else begin
            if (wr_en.chan) chan_q <= wdata[CHAN_W-1:0];
            if (wr_en.offs) offs_q <= wdata[OFFS_W-1:0];
        end
    end

    // Data register: bus write while idle, or read return on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (rd_done)    data_q <= rd_data;
        else if (wr_en.data) data_q <= wdata[DATA_W-1:0];
    end

    // Mode field and sticky error; a new error wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_en.ctrl) mode_q <= wdata[BIT_MODE+1:BIT_MODE];
            if (err_set)                        err_q <= 1'b1;
            else if (wr_en.ctrl && wdata[BIT_ERR]) err_q <= 1'b0;
        end
    end

    // Read mux, zero-extended; strobes always read as zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_CHAN)) rdata[CHAN_W-1:0] = chan_q;
        if (addr == ADDR_W'(ADDR_OFFS)) rdata[OFFS_W-1:0] = offs_q;
        if (addr == ADDR_W'(ADDR_DATA)) rdata[DATA_W-1:0] = data_q;
        if (addr == ADDR_W'(ADDR_CTRL)) begin
            rdata[BIT_MODE+1:BIT_MODE] = mode_q;
            rdata[BIT_BUSY]            = busy;
            rdata[BIT_ERR]             = err_q;
        end
    end
endmodule

// File: rtl/ind_access_port.sv
// Module: ind_access_port
// Top of the indirect access window: bus-side register window that
// launches single 16-bit accesses into a per-channel internal space over
// a request/acknowledge port. Assumes int_ack is a one-cycle pulse given
// only while int_req is high.
module ind_access_port
    import iap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BUS_W  = 32,
    parameter int CHAN_W = 8,
    parameter int OFFS_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              int_req,
    output logic              int_we,
    output logic [CHAN_W-1:0] int_chan,
    output logic [OFFS_W-1:0] int_offs,
    output logic [DATA_W-1:0] int_wdata,
    input  logic              int_ack,
    input  logic [DATA_W-1:0] int_rdata
);
    win_sel_t wr_en;
    logic     blocked;
    logic     busy;
    logic     launch_err;
    logic     rd_done;

    iap_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .busy    (busy),
        .wr_en   (wr_en),
        .blocked (blocked)
    );

    iap_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (wr_en.ctrl),
        .cmd        (bus_wdata[3:0]),
        .int_ack    (int_ack),
        .busy       (busy),
        .dir_we     (int_we),
        .launch_err (launch_err),
        .rd_done    (rd_done)
    );

    iap_regs #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .CHAN_W (CHAN_W),
        .OFFS_W (OFFS_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (bus_wdata),
        .addr    (bus_addr),
        .busy    (busy),
        .err_set (blocked | launch_err),
        .rd_done (rd_done),
        .rd_data (int_rdata),
        .chan_q  (int_chan),
        .offs_q  (int_offs),
        .data_q  (int_wdata),
        .rdata   (bus_rdata)
    );

    // Request follows the busy state of the sequencer
    assign int_req = busy;
endmodule

// File: rtl/iap_checker.sv
// Module: iap_checker
// Port-level protocol checks for ind_access_port, attached by bind.
// Assumes reset is asserted from time zero.
module iap_checker
    import iap_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int BUS_W  = 32,
    parameter int CHAN_W = 8,
    parameter int OFFS_W = 12,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              int_req,
    input logic              int_we,
    input logic [CHAN_W-1:0] int_chan,
    input logic [OFFS_W-1:0] int_offs,
    input logic [DATA_W-1:0] int_wdata,
    input logic              int_ack,
    input logic [DATA_W-1:0] int_rdata
);
    logic ctrl_idle_wr;
    assign ctrl_idle_wr = bus_wr && !int_req && (bus_addr == ADDR_W'(ADDR_CTRL));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !int_req);

    p_strobes_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(ADDR_CTRL)) |-> (bus_rdata[1:0] == 2'b00));

    p_read_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idle_wr && bus_wdata[3:0] == 4'h6) |=> (int_req && !int_we));

    p_write_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idle_wr && bus_wdata[3:0] == 4'h5) |=> (int_req && int_we));

    p_hold_until_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=> int_req);

    p_ack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack) |=> !int_req);

    p_read_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_ack && !int_we) |=>
        ((bus_addr != ADDR_W'(ADDR_DATA)) || (bus_rdata[DATA_W-1:0] == $past(int_rdata))));

    p_bad_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_idle_wr && bus_wdata[1:0] != 2'b00 &&
         (bus_wdata[3:2] != MODE_DIRECT || bus_wdata[1:0] == 2'b11)) |=> !int_req);

    p_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack) |=>
        ($stable(int_chan) && $stable(int_offs) && $stable(int_wdata)));
endmodule

bind ind_access_port iap_checker #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .CHAN_W (CHAN_W),
    .OFFS_W (OFFS_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .int_req   (int_req),
    .int_we    (int_we),
    .int_chan  (int_chan),
    .int_offs  (int_offs),
    .int_wdata (int_wdata),
    .int_ack   (int_ack),
    .int_rdata (int_rdata)
);

// File: tb/ind_access_port_bench.sv
// Bench for ind_access_port: directed corner cases plus seeded random
// indirect reads and writes against a behavioural internal register space.
module ind_access_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        int_req;
    logic        int_we;
    logic [7:0]  int_chan;
    logic [11:0] int_offs;
    logic [15:0] int_wdata;
    logic        int_ack = 1'b0;
    logic [15:0] int_rdata = '0;

    int checks = 0;
    int errors = 0;
    int req_count = 0;
    bit hold_ack = 1'b0;
    int lat = 0;
    int wait_cnt = 0;

    logic [15:0] rmem [0:1023];
    logic [15:0] emem [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_access_port u_ind_access_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_req   (int_req),
        .int_we    (int_we),
        .int_chan  (int_chan),
        .int_offs  (int_offs),
        .int_wdata (int_wdata),
        .int_ack   (int_ack),
        .int_rdata (int_rdata)
    );

    function automatic int mkey(logic [7:0] ch, logic [11:0] of);
        return int'({ch[1:0], of[7:0]});
    endfunction

    function automatic logic [31:0] ctrl_exp(logic [1:0] mode, bit busy, bit err);
        return {22'd0, err, busy, 4'd0, mode, 2'b00};
    endfunction

    // Behavioural internal register space with variable latency
    always @(posedge clk) begin
        if (!rst_n) begin
            int_ack  <= 1'b0;
            wait_cnt <= 0;
        end else if (int_ack) begin
            int_ack <= 1'b0;
        end else if (int_req && !hold_ack) begin
            if (wait_cnt >= lat) begin
                int_ack   <= 1'b1;
                int_rdata <= rmem[mkey(int_chan, int_offs)];
                if (int_we) rmem[mkey(int_chan, int_offs)] <= int_wdata;
                req_count <= req_count + 1;
                wait_cnt  <= 0;
                lat       <= int'($urandom % 5);
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        bit done = 1'b0;
        for (int i = 0; i < 60 && !done; i++) begin
            bus_read(7'h3A, v);
            if (!v[8]) done = 1'b1;
        end
        if (!done) chk("R6 busy never cleared", 32'd1, 32'd0);
    endtask

    initial begin
        logic [31:0] v;
        int rq;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 1024; i++) begin
            rmem[i] = '0;
            emem[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        bus_read(7'h38, v); chk("R1 chan", v, 32'h0);
        bus_read(7'h3A, v); chk("R1 ctrl", v, 32'h0);
        bus_read(7'h3B, v); chk("R1 offs", v, 32'h0);
        bus_read(7'h3C, v); chk("R1 data", v, 32'h0);
        chk("R1 int_req", {31'd0, int_req}, 32'h0);

        // R2: widths and unmapped address
        bus_write(7'h38, 32'hFFFF_FFFF); bus_read(7'h38, v); chk("R2 chan width", v, 32'hFF);
        bus_write(7'h3B, 32'hFFFF_FFFF); bus_read(7'h3B, v); chk("R2 offs width", v, 32'hFFF);
        bus_write(7'h3C, 32'hFFFF_FFFF); bus_read(7'h3C, v); chk("R2 data width", v, 32'hFFFF);
        bus_read(7'h39, v); chk("R2 unmapped", v, 32'h0);

        // R3: mode field only, no strobes
        bus_write(7'h3A, 32'hFFFF_FCFC); bus_read(7'h3A, v); chk("R3 ctrl layout", v, ctrl_exp(2'b11, 0, 0));

        // R5 then R4: write then read back one location
        rq = req_count;
        bus_write(7'h38, 32'h1);
        bus_write(7'h3B, 32'h135);
        bus_write(7'h3C, 32'hBEEF);
        hold_ack = 1'b1;
        bus_write(7'h3A, 32'h5);
        chk("R5 int_we", {31'd0, int_we}, 32'h1);
        chk("R5 int_wdata", {16'd0, int_wdata}, 32'hBEEF);
        chk("R5 int_offs", {20'd0, int_offs}, 32'h135);
        hold_ack = 1'b0;
        wait_idle();
        emem[mkey(8'h1, 12'h135)] = 16'hBEEF;
        chk("R5 one access", req_count - rq, 32'd1);
        bus_write(7'h3C, 32'h0);
        hold_ack = 1'b1;
        bus_write(7'h3A, 32'h6);
        chk("R4 int_req", {31'd0, int_req}, 32'h1);
        chk("R4 int_we", {31'd0, int_we}, 32'h0);
        bus_read(7'h3A, v); chk("R3 strobes cleared, R6 busy", v, ctrl_exp(2'b01, 1, 0));
        hold_ack = 1'b0;
        wait_idle();
        bus_read(7'h3C, v); chk("R6 read capture", v, 32'hBEEF);

        // R7 and R10: writes while busy are dropped
        bus_write(7'h38, 32'h3);
        bus_write(7'h3B, 32'h137);
        hold_ack = 1'b1;
        bus_write(7'h3A, 32'h6);
        bus_write(7'h38, 32'h9);
        bus_write(7'h3B, 32'h15E);
        bus_write(7'h3C, 32'h1234);
        bus_read(7'h38, v); chk("R7 chan kept", v, 32'h3);
        bus_read(7'h3B, v); chk("R7 offs kept", v, 32'h137);
        chk("R10 int_chan steady", {24'd0, int_chan}, 32'h3);
        chk("R10 int_offs steady", {20'd0, int_offs}, 32'h137);
        bus_read(7'h3A, v); chk("R7 error set", v, ctrl_exp(2'b01, 1, 1));
        bus_write(7'h3A, 32'h200);
        bus_read(7'h3A, v); chk("R7 ctrl write dropped", v, ctrl_exp(2'b01, 1, 1));
        hold_ack = 1'b0;
        wait_idle();
        bus_read(7'h3A, v); chk("R6 busy clear", v, ctrl_exp(2'b01, 0, 1));

        // R9: write-one-to-clear
        bus_write(7'h3A, 32'h204);
        bus_read(7'h3A, v); chk("R9 error cleared", v, ctrl_exp(2'b01, 0, 0));

        // R8: bad mode and both strobes
        rq = req_count;
        bus_write(7'h3A, 32'h2);
        repeat (8) @(negedge clk);
        chk("R8 bad mode no access", req_count - rq, 32'd0);
        bus_read(7'h3A, v); chk("R8 bad mode error", v, ctrl_exp(2'b00, 0, 1));
        bus_write(7'h3A, 32'h204);
        bus_read(7'h3A, v); chk("R9 clear again", v, ctrl_exp(2'b01, 0, 0));
        bus_write(7'h3A, 32'h7);
        repeat (8) @(negedge clk);
        chk("R8 both strobes no access", req_count - rq, 32'd0);
        bus_read(7'h3A, v); chk("R8 both strobes error", v, ctrl_exp(2'b01, 0, 1));
        bus_write(7'h3A, 32'h20D);
        bus_read(7'h3A, v); chk("R9 set wins over clear", v, ctrl_exp(2'b11, 0, 1));
        bus_write(7'h3A, 32'h204);

        // R4 R5 R6: seeded random indirect traffic
        for (int n = 0; n < 160; n++) begin
            logic [7:0]  ch;
            logic [11:0] of;
            logic [15:0] d;
            int          sel;
            ch  = 8'($urandom % 4);
            sel = int'($urandom % 6);
            case (sel)
                0: of = 12'h135;
                1: of = 12'h137;
                2: of = 12'h15E;
                3: of = 12'h164;
                default: of = 12'($urandom % 512);
            endcase
            bus_write(7'h38, {24'd0, ch});
            bus_write(7'h3B, {20'd0, of});
            if ($urandom % 2 == 0) begin
                d = 16'($urandom);
                bus_write(7'h3C, {16'd0, d});
                bus_write(7'h3A, 32'h5);
                wait_idle();
                emem[mkey(ch, of)] = d;
            end else begin
                bus_write(7'h3A, 32'h6);
                wait_idle();
                bus_read(7'h3C, v);
                chk("R4/R6 random read", v, {16'd0, emem[mkey(ch, of)]});
            end
        end
        bus_read(7'h3A, v); chk("R3 final ctrl", v, ctrl_exp(2'b01, 0, 0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule